// File: doc/BRIEF.md
# Selectable-Order Spline Interpolator

This block produces one parameter sample on every base clock for an oscillator input such as amplitude, offset, frequency or phase. A control interface presents a knot: a start value and up to three difference coefficients. From the following clock edge on, the block steps the curve forward by adding coefficients, and it keeps doing so until another knot arrives. The knot computation and the knot storage sit outside the block.

The order is fixed for each instance by a parameter. Order 0 holds the knot value, which suits phase words. Order 1 adds a constant slope each cycle, which suits frequency words. Order 3 runs a chain of three running sums, which suits amplitude and offset. Every order has the same knot-to-output latency, so several instances that load on the same edge stay aligned. The coefficient registers hold extra fraction bits below the output LSB. This lets slow ramps accumulate without visible rounding drift.

Top module: `spline_interp`

## Requirements
- R1: A synchronous active-high `rst` clears the value register and every coefficient register. `value_out` is then 0 and remains 0 until a knot is loaded.
- R2: When `knot_load` is high at a rising edge, the value register takes `knot_value` with its fraction bits zero, and coefficient k takes `knot_dk`. Right after that edge `value_out` equals `knot_value`. This one-edge latency is the same for every order.
- R3: With ORDER = 0, `value_out` holds the knot value on every cycle without a load. The coefficient inputs have no effect.
- R4: With ORDER = 1, each edge without a load adds coefficient 1 to the value. After n such edges `value_out` is bits [W+F-1:F] of knot_value·2^F + n·d1.
- R5: With ORDER = 3, each edge without a load performs value += d1, d1 += d2 and d2 += d3, all from the values held before the edge. d3 is held. After n edges `value_out` is bits [W+F-1:F] of knot_value·2^F + n·d1 + n(n-1)/2·d2 + n(n-1)(n-2)/6·d3.
- R6: A knot can be loaded on any cycle, including in the middle of a ramp and on consecutive cycles. The latest load replaces the value and all coefficients. No earlier coefficient affects the output afterwards.
- R7: Coefficients are W+F-bit two's complement numbers with F fraction bits. A step smaller than one output LSB accumulates across cycles. For example, d1 = 2^(F-2) raises the output by one LSB every four steps.
- R8: All sums wrap modulo 2^(W+F), with no saturation.
- R9: The width is a parameter. A 48-bit linear instance follows R4 across carries out of the low 32 output bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous active-high reset |
| knot_load | input | 1 | Load the knot presented on this edge |
| knot_value | input | W | Start value of the segment |
| knot_d1 | input | W+F | First difference coefficient, signed, F fraction bits |
| knot_d2 | input | W+F | Second difference coefficient, signed |
| knot_d3 | input | W+F | Third difference coefficient, signed |
| value_out | output | W | Registered interpolated sample |

## Verification
The bench drives one knot stream into constant, linear and cubic instances in parallel. It compares each output with a closed-form polynomial in the step count, so each stimulus shows whether the order selection and the accumulation order are right. Several stimulus patterns are used:
- a steep cubic with all three coefficients nonzero;
- a negative fractional slope;
- a quarter-LSB slope that exposes lost fraction bits;
- a ramp that crosses full scale to show wraparound.

Mid-ramp reloads, back-to-back loads and a reset during a ramp followed by idle cycles show whether stale coefficients survive. A 48-bit linear instance checks carries across wide words.

// File: rtl/spline_pkg.sv
package spline_pkg;

  localparam int unsigned MAX_ORDER = 3;

  // number of accumulator registers an order needs (value plus one per difference)
  function automatic int unsigned stage_count(input int unsigned order);
    return order + 1;
  endfunction

endpackage

// File: rtl/spline_acc_stage.sv
module spline_acc_stage #(
  parameter int unsigned AW      = 32,
  parameter bit          HAS_INC = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] init,
  input  logic [AW-1:0] inc,
  output logic [AW-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (load) begin
      q <= init;
    end else begin
      q <= q + (HAS_INC ? inc : '0);
    end
  end

endmodule

// File: rtl/spline_interp.sv
module spline_interp #(
  parameter int unsigned W     = 16,
  parameter int unsigned F     = 16,
  parameter int unsigned ORDER = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             knot_load,
  input  logic [W-1:0]     knot_value,
  input  logic [W+F-1:0]   knot_d1,
  input  logic [W+F-1:0]   knot_d2,
  input  logic [W+F-1:0]   knot_d3,
  output logic [W-1:0]     value_out
);

  localparam int unsigned AW  = W + F;
  localparam int unsigned NST = spline_pkg::stage_count(ORDER);

  logic [AW-1:0] coef [spline_pkg::MAX_ORDER+1];
  logic [AW-1:0] acc  [NST];

  assign coef[0] = {knot_value, {F{1'b0}}};
  assign coef[1] = knot_d1;
  assign coef[2] = knot_d2;
  assign coef[3] = knot_d3;

  // stage k holds difference k; every stage below the top adds its upper neighbour
  for (genvar k = 0; k < NST; k++) begin : g_stage
    logic [AW-1:0] inc;
    if (k < ORDER) begin : g_inc
      assign inc = acc[k+1];
    end else begin : g_top
      assign inc = '0;
    end
    spline_acc_stage #(
      .AW      (AW),
      .HAS_INC (k < ORDER)
    ) u_stage (
      .clk  (clk),
      .rst  (rst),
      .load (knot_load),
      .init (coef[k]),
      .inc  (inc),
      .q    (acc[k])
    );
  end

  assign value_out = acc[0][AW-1:F];

endmodule

// File: rtl/spline_interp_chk.sv
module spline_interp_chk #(
  parameter int unsigned W     = 16,
  parameter int unsigned F     = 16,
  parameter int unsigned ORDER = 3
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 knot_load,
  input logic [W-1:0]         knot_value,
  input logic [W-1:0]         value_out,
  input logic [W+F-1:0]       acc [ORDER+1]
);

  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  // R1: one edge after a reset edge the output is zero
  always @(posedge clk) begin
    if (rst_q === 1'b1) begin
      a_r1_reset_clear: assert (value_out == '0);
    end
  end

  // R2: loaded knot value appears after exactly one edge
  a_r2_load_value: assert property (@(posedge clk) disable iff (rst)
    knot_load |=> value_out == $past(knot_value));

  if (ORDER == 0) begin : g_const
    // R3: constant order holds between knots
    a_r3_const_hold: assert property (@(posedge clk) disable iff (rst)
      !knot_load |=> $stable(value_out));
  end else begin : g_step
    // R4: value advances by the first difference
    a_r4_value_step: assert property (@(posedge clk) disable iff (rst)
      !knot_load |=> acc[0] == $past(acc[0]) + $past(acc[1]));
    // R5: highest difference is held between knots
    a_r5_top_hold: assert property (@(posedge clk) disable iff (rst)
      !knot_load |=> $stable(acc[ORDER]));
  end

  if (ORDER >= 2) begin : g_chain
    // R5: first difference advances by the second
    a_r5_d1_step: assert property (@(posedge clk) disable iff (rst)
      !knot_load |=> acc[1] == $past(acc[1]) + $past(acc[2]));
  end

endmodule

bind spline_interp spline_interp_chk #(
  .W     (W),
  .F     (F),
  .ORDER (ORDER)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .knot_load  (knot_load),
  .knot_value (knot_value),
  .value_out  (value_out),
  .acc        (acc)
);

// File: tb/test_spline_interp.sv
module test_spline_interp;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load = 1'b0;
  logic [15:0] kv = '0;
  logic [31:0] d1 = '0, d2 = '0, d3 = '0;
  logic [15:0] out_cub, out_lin, out_con;
  logic [47:0] wv = '0;
  logic [63:0] wd1 = '0;
  logic [47:0] out_wide;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spline_interp #(.W(16), .F(16), .ORDER(3)) i_spline_interp (
    .clk(clk), .rst(rst), .knot_load(load), .knot_value(kv),
    .knot_d1(d1), .knot_d2(d2), .knot_d3(d3), .value_out(out_cub));

  spline_interp #(.W(16), .F(16), .ORDER(1)) i_spline_interp_lin (
    .clk(clk), .rst(rst), .knot_load(load), .knot_value(kv),
    .knot_d1(d1), .knot_d2(d2), .knot_d3(d3), .value_out(out_lin));

  spline_interp #(.W(16), .F(16), .ORDER(0)) i_spline_interp_con (
    .clk(clk), .rst(rst), .knot_load(load), .knot_value(kv),
    .knot_d1(d1), .knot_d2(d2), .knot_d3(d3), .value_out(out_con));

  spline_interp #(.W(48), .F(16), .ORDER(1)) i_spline_interp_wide (
    .clk(clk), .rst(rst), .knot_load(load), .knot_value(wv),
    .knot_d1(wd1), .knot_d2(64'h0), .knot_d3(64'h0), .value_out(out_wide));

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] model_lin(logic [15:0] v, logic [31:0] a, int n);
    logic [31:0] s;
    s = {v, 16'h0} + 32'(n) * a;
    return s[31:16];
  endfunction

  function automatic logic [15:0] model_cub(logic [15:0] v, logic [31:0] a,
                                            logic [31:0] b, logic [31:0] c, int n);
    logic [31:0] s;
    s = {v, 16'h0} + 32'(n) * a + 32'(n * (n - 1) / 2) * b
        + 32'(n * (n - 1) * (n - 2) / 6) * c;
    return s[31:16];
  endfunction

  // present a knot at a falling edge; it is taken on the next rising edge
  task automatic present(input logic [15:0] v, input logic [31:0] a,
                         input logic [31:0] b, input logic [31:0] c);
    kv = v; d1 = a; d2 = b; d3 = c; load = 1'b1;
    @(posedge clk);
    @(negedge clk);
  endtask

  // after present(): release the load, then check steps 0..nmax on all three small instances
  task automatic follow(input string tag, input int nmax);
    load = 1'b0;
    for (int n = 0; n <= nmax; n++) begin
      if (n > 0) @(negedge clk);
      check({tag, "/R3 const"}, 64'(out_con), 64'(kv));
      check({tag, "/R4 linear"}, 64'(out_lin), 64'(model_lin(kv, d1, n)));
      check({tag, "/R5 cubic"}, 64'(out_cub), 64'(model_cub(kv, d1, d2, d3, n)));
    end
  endtask

  task automatic t_reset_state();
    check("R1 reset cubic", 64'(out_cub), 64'h0);
    check("R1 reset linear", 64'(out_lin), 64'h0);
    check("R1 reset const", 64'(out_con), 64'h0);
    check("R1 reset wide", 64'(out_wide), 64'h0);
  endtask

  task automatic t_load_latency();
    present(16'h1234, 32'h0003_0000, 32'h0001_0000, 32'h0000_8000);
    check("R2 latency cubic", 64'(out_cub), 64'h1234);
    check("R2 latency linear", 64'(out_lin), 64'h1234);
    check("R2 latency const", 64'(out_con), 64'h1234);
    follow("R2", 0);
  endtask

  task automatic t_cubic_full();
    present(16'h0100, 32'h0002_4000, 32'hFFFF_C000, 32'h0000_2000);
    follow("R5 steep", 30);
  endtask

  task automatic t_negative_frac();
    present(16'h8000, 32'hFFFE_8000, 32'h0000_0000, 32'h0000_0000);
    follow("R7 negative", 20);
  endtask

  task automatic t_quarter_lsb();
    present(16'h0040, 32'h0000_4000, 32'h0000_0800, 32'hFFFF_FF00);
    follow("R7 quarter", 24);
    check("R7 quarter linear after 24", 64'(out_lin), 64'h0046);
  endtask

  task automatic t_wrap();
    present(16'hFFF0, 32'h0004_0000, 32'h0000_0000, 32'h0000_0000);
    follow("R8 wrap", 8);
    check("R8 wrap linear", 64'(out_lin), 64'h0010);
  endtask

  task automatic t_reload_mid_ramp();
    present(16'h2000, 32'h0010_0000, 32'h0002_0000, 32'h0001_0000);
    follow("R6 first", 5);
    present(16'h0500, 32'hFFFF_0000, 32'h0000_0000, 32'h0000_0000);
    follow("R6 reload", 10);
    check("R6 reload cubic no leak", 64'(out_cub), 64'h04F6);
  endtask

  task automatic t_back_to_back();
    kv = 16'h7000; d1 = 32'h0100_0000; d2 = 32'h0010_0000; d3 = 32'h0001_0000;
    load = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R6 b2b first cubic", 64'(out_cub), 64'h7000);
    kv = 16'h0300; d1 = 32'h0001_0000; d2 = 32'h0000_0000; d3 = 32'h0000_0000;
    @(posedge clk);
    @(negedge clk);
    follow("R6 b2b second", 6);
  endtask

  task automatic t_reset_mid_ramp();
    present(16'h3000, 32'h0005_0000, 32'h0001_0000, 32'h0000_1000);
    follow("R1 ramp", 3);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset_state();
    repeat (4) @(negedge clk);
    check("R1 idle cubic", 64'(out_cub), 64'h0);
    check("R1 idle linear", 64'(out_lin), 64'h0);
    check("R1 idle wide", 64'(out_wide), 64'h0);
  endtask

  task automatic t_wide();
    logic [63:0] s;
    wv = 48'h0000_FFFF_FFF0;
    wd1 = 64'h0000_0000_0010_8000;
    load = 1'b1;
    @(posedge clk);
    @(negedge clk);
    load = 1'b0;
    for (int n = 0; n <= 12; n++) begin
      if (n > 0) @(negedge clk);
      s = {wv, 16'h0} + 64'(n) * wd1;
      check("R9 wide linear", 64'(out_wide), 64'(s[63:16]));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    rst = 1'b0;
    @(negedge clk);
    t_reset_state();
    t_load_latency();
    t_cubic_full();
    t_negative_frac();
    t_quarter_lsb();
    t_wrap();
    t_reload_mid_ramp();
    t_back_to_back();
    t_wide();
    t_reset_mid_ramp();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule